// File: doc/BRIEF.md
# Pulse-Width Event Counter

This block measures how long an asynchronous external input stays at a chosen level, in bus-clock cycles. Software writes a three-bit control word that turns the measurement on, chooses whether the high or the low level is timed, and chooses what happens when the 16-bit count runs past its maximum. With the stop policy the counter clears itself and drops its own enable bit. With the wrap policy it rolls over and keeps counting. Each overflow produces a one-cycle event pulse, which feeds a shared interrupt status bit kept outside this block.

The external input first passes through a two-flop synchronizer. A state machine then tracks the measurement. `ST_OFF` means the enable bit is clear and the count is frozen. `ST_WAIT` means the block is enabled and the input is at the non-timed level, and the last measured width is held for reading. `ST_MEASURE` means a qualifying period is being timed. The transitions are:

- `ST_OFF` to `ST_WAIT` (arm): the enable bit is set.
- `ST_WAIT` to `ST_MEASURE` (start): the synchronized level matches. The count restarts at 1.
- `ST_MEASURE` to `ST_WAIT` (end): the level stops matching. The count holds.
- `ST_MEASURE` to `ST_OFF` (auto-stop): the count overflows while the stop policy is selected.
- `ST_WAIT` or `ST_MEASURE` to `ST_OFF` (disarm): software clears the enable bit.

Top module: `pwc_event_timer`

## Requirements
- R1: After reset, `count`, `ctrl_rdata` and `ovf_evt` are all 0.
- R2: A write through `ctrl_wr` stores `ctrl_wdata` and the value reads back on `ctrl_rdata` from the next cycle. The bit fields are: bit 0 enable, bit 1 level select, bit 2 overflow-continue.
- R3: With level select 0, a high pulse that lasts N clock cycles leaves `count` equal to N.
- R4: With level select 1, a low pulse that lasts N clock cycles leaves `count` equal to N.
- R5: Every new qualifying period restarts the count from 0, so `count` shows only the width of the latest period.
- R6: After a period ends, `count` holds the measured width for as long as the input stays at the other level.
- R7: While enable is 0, `count` does not change, whatever `ext_in` does.
- R8: If overflow-continue is 0 and the count overflows, `count` becomes 0 and the enable bit clears. `count` then stays 0 until software sets enable again.
- R9: If overflow-continue is 1, the count wraps past its maximum and keeps counting, so a period of N cycles reads back as N mod 65536 and enable stays set.
- R10: Each overflow raises `ovf_evt` for exactly one clock cycle.
- R11: `count` first changes on the third rising clock edge after `ext_in` moves to the timed level, counting the two synchronizer flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the unit of counting |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 3 | Control word to write (bit 0 enable, bit 1 level select, bit 2 overflow-continue) |
| ctrl_rdata | output | 3 | Current control word, including enable cleared by auto-stop |
| ext_in | input | 1 | Asynchronous external level to measure |
| count | output | 16 | Latest measured width, read-only |
| ovf_evt | output | 1 | One-cycle pulse on count overflow |

## Verification
The hardest situation to reach from the ports is the overflow: the input has to stay at the timed level for more than 65535 consecutive cycles, and under the stop policy the block must then clear and disarm itself on that exact edge. The bench drives two directed marathon pulses, one under each policy, that run a few cycles past the overflow point. It then checks the residual count, the enable bit and the number of event pulses. Shorter random pulses with random widths and random levels cover the restart and hold behaviour between them.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    localparam int CTRL_W = 3;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_WAIT    = 2'd1,
        ST_MEASURE = 2'd2
    } pwc_state_e;

    // Packed MSB first: enable lands on bit 0
    typedef struct packed {
        logic ovf_cont;
        logic lvl_low;
        logic enable;
    } pwc_ctrl_t;

endpackage

// File: rtl/pwc_sync.sv
module pwc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
    import pwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              auto_off,
    output pwc_ctrl_t         ctrl_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_en) ctrl_q <= pwc_ctrl_t'(wr_data);
            // Self-disarm wins over a write landing on the same edge
            if (auto_off) ctrl_q.enable <= 1'b0;
        end
    end

endmodule

// File: rtl/pwc_fsm.sv
module pwc_fsm
    import pwc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             lvl_low,
    input  logic             ovf_cont,
    input  logic             sync_lvl,
    output logic [CNT_W-1:0] count_q,
    output logic             ovf_evt,
    output logic             auto_off
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    pwc_state_e state_q, state_d;
    logic       match;
    logic       wrap;

    assign match    = sync_lvl ^ lvl_low;
    assign wrap     = (state_q == ST_MEASURE) && enable && match && (&count_q);
    assign auto_off = wrap && !ovf_cont;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (enable) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!enable)    state_d = ST_OFF;
                else if (match) state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (!enable)       state_d = ST_OFF;
                else if (auto_off) state_d = ST_OFF;
                else if (!match)   state_d = ST_WAIT;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs: count and overflow event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= CNT_ZERO;
            ovf_evt <= 1'b0;
        end else begin
            ovf_evt <= wrap;
            unique case (state_q)
                ST_OFF: begin
                    count_q <= count_q;
                end
                ST_WAIT: begin
                    if (enable && match) count_q <= CNT_ONE;
                end
                ST_MEASURE: begin
                    if (enable && match) begin
                        if (wrap) count_q <= CNT_ZERO;
                        else      count_q <= count_q + CNT_ONE;
                    end
                end
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/pwc_event_timer.sv
module pwc_event_timer
    import pwc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              ext_in,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_evt
);

    pwc_ctrl_t ctrl_q;
    logic      sync_lvl;
    logic      auto_off;

    pwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_in),
        .sync_out (sync_lvl)
    );

    pwc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .wr_data  (ctrl_wdata),
        .auto_off (auto_off),
        .ctrl_q   (ctrl_q)
    );

    pwc_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ctrl_q.enable),
        .lvl_low  (ctrl_q.lvl_low),
        .ovf_cont (ctrl_q.ovf_cont),
        .sync_lvl (sync_lvl),
        .count_q  (count),
        .ovf_evt  (ovf_evt),
        .auto_off (auto_off)
    );

    assign ctrl_rdata = ctrl_q;

endmodule

// File: rtl/pwc_event_timer_chk.sv
module pwc_event_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       ctrl_rdata,
    input logic [CNT_W-1:0] count,
    input logic             ovf_evt
);

    // R10
    ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> !ovf_evt);

    // R9
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |-> (count == '0));

    // R8
    ovf_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !$past(ctrl_rdata[2])) |-> !ctrl_rdata[0]);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[0] |=> $stable(count));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |->
            ((count == CNT_W'($past(count) + 1'b1)) || (count == CNT_W'(1)) || (count == '0)));

endmodule

bind pwc_event_timer pwc_event_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_rdata (ctrl_rdata),
    .count      (count),
    .ovf_evt    (ovf_evt)
);

// File: tb/pwc_event_timer_test.sv
module pwc_event_timer_test;

    localparam int CNT_W = 16;
    localparam int WDOG  = 190000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctrl_wr = 1'b0;
    logic [2:0]       ctrl_wdata = '0;
    logic [2:0]       ctrl_rdata;
    logic             ext_in = 1'b0;
    logic [CNT_W-1:0] count;
    logic             ovf_evt;

    int n_chk = 0;
    int n_bad = 0;
    int ovf_seen = 0;
    int ovf_double = 0;
    logic ovf_prev = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    pwc_event_timer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .ext_in     (ext_in),
        .count      (count),
        .ovf_evt    (ovf_evt)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (ovf_evt) ovf_seen++;
            if (ovf_evt && ovf_prev) ovf_double++;
            ovf_prev = ovf_evt;
        end
    end

    function automatic int exp_width(input int n, input bit cont);
        if (cont) return n % (1 << CNT_W);
        if (n >= (1 << CNT_W)) return 0;
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [2:0] d);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = d;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic drive_pulse(input logic act, input int n);
        @(negedge clk);
        ext_in = act;
        repeat (n) @(negedge clk);
        ext_in = ~act;
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int prev;
        int base_ovf;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 count", int'(count), 0);
        check("R1 ctrl", int'(ctrl_rdata), 0);
        check("R1 ovf", int'(ovf_evt), 0);

        // R2 readback of the control fields
        wr_ctrl(3'b110);
        check("R2 readback", int'(ctrl_rdata), 6);
        wr_ctrl(3'b001);
        check("R2 readback", int'(ctrl_rdata), 1);
        repeat (4) @(negedge clk);

        // R11 latency through the synchronizer, R3 width
        ext_in = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R11 before third edge", int'(count), 0);
        @(negedge clk);
        check("R11 third edge", int'(count), 1);
        repeat (7) @(negedge clk);
        ext_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R3 width", int'(count), 10);
        // R6 hold
        repeat (20) @(negedge clk);
        check("R6 hold", int'(count), 10);

        // Random widths and levels: R3, R4, R5
        for (int i = 0; i < 25; i++) begin
            logic lvl;
            logic act;
            int n1;
            int n2;
            lvl = 1'($urandom_range(0, 1));
            act = ~lvl;
            n1 = int'($urandom_range(20, 300));
            n2 = int'($urandom_range(1, 19));
            wr_ctrl({1'b0, lvl, 1'b1});
            ext_in = ~act;
            repeat (4) @(negedge clk);
            drive_pulse(act, n1);
            check(lvl ? "R4 low width" : "R3 high width", int'(count), n1);
            repeat (int'($urandom_range(0, 10))) @(negedge clk);
            check("R6 hold between", int'(count), n1);
            drive_pulse(act, n2);
            check("R5 restart", int'(count), n2);
        end

        // R7 disabled: no counting
        wr_ctrl(3'b000);
        ext_in = 1'b0;
        repeat (4) @(negedge clk);
        prev = int'(count);
        drive_pulse(1'b1, 50);
        check("R7 disabled hold", int'(count), prev);

        // R9 wrap and keep counting
        wr_ctrl(3'b101);
        repeat (4) @(negedge clk);
        base_ovf = ovf_seen;
        drive_pulse(1'b1, 65536 + 7);
        check("R9 wrapped count", int'(count), exp_width(65536 + 7, 1'b1));
        check("R9 enable kept", int'(ctrl_rdata[0]), 1);
        check("R10 one event", ovf_seen - base_ovf, 1);

        // R8 auto-stop and clear
        wr_ctrl(3'b001);
        repeat (4) @(negedge clk);
        base_ovf = ovf_seen;
        drive_pulse(1'b1, 65536 + 20);
        check("R8 cleared count", int'(count), exp_width(65536 + 20, 1'b0));
        check("R8 enable cleared", int'(ctrl_rdata[0]), 0);
        check("R10 one event", ovf_seen - base_ovf, 1);
        drive_pulse(1'b1, 30);
        check("R8 stays zero", int'(count), 0);
        wr_ctrl(3'b001);
        repeat (6) @(negedge clk);
        check("R8 zero after re-enable", int'(count), 0);
        drive_pulse(1'b1, 5);
        check("R8 counts after re-enable", int'(count), 5);
        check("R10 single-cycle pulses", ovf_double, 0);

        done = 1'b1;
        finish_run();
    end

endmodule